// File: doc/BRIEF.md
# Single-Cycle Four-Operation Processor Core

This core runs a tiny register-register instruction set with four operations: add, branch when a register is zero, load and store. Every clock cycle it presents its program counter on the instruction port, decodes the returned word, reads its operands from a 32-entry register file, and retires the instruction at the next rising edge. Each instruction updates the register file, data memory and program counter in that one cycle.

Both memories live outside the core. The instruction and data read ports are combinational: the data for an address comes back in the same cycle. A data write is presented with a write strobe and commits at the next rising edge. Addresses count words, so sequential flow moves the program counter by one. A taken branch loads the program counter from a register.

Top module: `sc4_core`

## Requirements
- R1: While `rst` is high at a rising edge, the program counter becomes zero and every register becomes zero. `dmem_we` stays low while `rst` is high. A store retired right after reset sends value 0 to address 0.
- R2: An instruction word carries the opcode in bits 31:30: 00 add, 01 branch-if-zero, 10 load, 11 store. Field A is in bits 29:25, field B in bits 24:20 and field C in bits 19:15. Bits 14:0, and field C of every non-add instruction, have no effect.
- R3: Add writes field-B register + field-C register, modulo 2^32, into the field-A register. The program counter then advances by one.
- R4: Branch-if-zero with a field-A register equal to zero sets the program counter to the value of the field-B register.
- R5: Branch-if-zero with a nonzero field-A register advances the program counter by one, as do add, load and store.
- R6: Load drives `dmem_addr` with the field-B register in the same cycle. It writes `dmem_rdata` into the field-A register and advances the program counter by one.
- R7: Store raises `dmem_we` and drives `dmem_addr` with the field-B register and `dmem_wdata` with the field-A register, all in the same cycle. It changes no register.
- R8: `dmem_we` is low for add, branch-if-zero and load.
- R9: `imem_addr` always equals the program counter. An instruction that reads a register written by the previous instruction sees the new value. An instruction whose destination equals one of its sources reads the old value.
- R10: Advancing the program counter from 0xFFFFFFFF gives 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| imem_addr | output | 32 | Instruction word address (program counter) |
| imem_rdata | input | 32 | Instruction word at `imem_addr`, same cycle |
| dmem_addr | output | 32 | Data word address |
| dmem_rdata | input | 32 | Data word at `dmem_addr`, same cycle |
| dmem_wdata | output | 32 | Data to write |
| dmem_we | output | 1 | Write strobe; commits at the next rising edge |

## Verification
A wrong register value stays hidden until a later instruction uses that register. It surfaces as a wrong `dmem_addr` or `dmem_wdata` on the next load or store, or as a wrong `imem_addr` one cycle after a branch. The programs therefore feed each result into an address, a store value or a branch condition within a few instructions. A wrong program counter shows on `imem_addr` in the very next cycle. A wrong decode shows on `dmem_we` in the same cycle.

// File: rtl/sc4_pkg.sv
package sc4_pkg;

    localparam int XLEN    = 32;
    localparam int NREGS   = 32;
    localparam int RIDX    = $clog2(NREGS);
    localparam int OPW     = 2;
    localparam int FA_LSB  = XLEN - OPW - RIDX;
    localparam int FB_LSB  = FA_LSB - RIDX;
    localparam int FC_LSB  = FB_LSB - RIDX;

    typedef logic [XLEN-1:0] word_t;
    typedef logic [RIDX-1:0] ridx_t;

    typedef enum logic [OPW-1:0] {
        OP_ADD   = 2'b00,
        OP_BZ    = 2'b01,
        OP_LOAD  = 2'b10,
        OP_STORE = 2'b11
    } opcode_e;

    // Port X and port Y select which register feeds each read port.
    typedef struct packed {
        opcode_e op;
        ridx_t   rx;
        ridx_t   ry;
        ridx_t   rw;
        logic    rf_we;
        logic    wb_mem;
        logic    mem_we;
        logic    is_branch;
    } ctl_t;

    function automatic ctl_t decode_word(word_t w);
        ctl_t  c;
        ridx_t fa;
        ridx_t fb;
        ridx_t fc;
        fa          = w[FA_LSB +: RIDX];
        fb          = w[FB_LSB +: RIDX];
        fc          = w[FC_LSB +: RIDX];
        c.op        = opcode_e'(w[XLEN-1 -: OPW]);
        c.rw        = fa;
        c.rx        = (c.op == OP_ADD) ? fb : fa;
        c.ry        = (c.op == OP_ADD) ? fc : fb;
        c.rf_we     = (c.op == OP_ADD) || (c.op == OP_LOAD);
        c.wb_mem    = (c.op == OP_LOAD);
        c.mem_we    = (c.op == OP_STORE);
        c.is_branch = (c.op == OP_BZ);
        return c;
    endfunction

endpackage

// File: rtl/sc4_decode.sv
module sc4_decode
    import sc4_pkg::*;
(
    input  word_t instr,
    output ctl_t  ctl
);
    always_comb begin
        ctl = decode_word(instr);
    end
endmodule

// File: rtl/sc4_regfile.sv
module sc4_regfile #(
    parameter  int NREGS = 32,
    parameter  int W     = 32,
    localparam int AW    = $clog2(NREGS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [AW-1:0] ra_x,
    input  logic [AW-1:0] ra_y,
    output logic [W-1:0]  rd_x,
    output logic [W-1:0]  rd_y,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata
);
    logic [W-1:0]     regs [NREGS];
    logic [NREGS-1:0] hit;

    for (genvar i = 0; i < NREGS; i++) begin : g_sel
        assign hit[i] = we && (waddr == AW'(i));
    end

    always_ff @(posedge clk) begin
        for (int i = 0; i < NREGS; i++) begin
            if (rst) begin
                regs[i] <= '0;
            end else if (hit[i]) begin
                regs[i] <= wdata;
            end
        end
    end

    assign rd_x = regs[ra_x];
    assign rd_y = regs[ra_y];

    // R6, R3: a write request is visible in the addressed register after the edge
    a_r6_write_lands: assert property (@(posedge clk) disable iff (rst)
        we |=> regs[$past(waddr)] == $past(wdata));
endmodule

// File: rtl/sc4_next_pc.sv
module sc4_next_pc
    import sc4_pkg::*;
(
    input  word_t pc,
    input  logic  is_branch,
    input  word_t cond_val,
    input  word_t target,
    output word_t pc_nxt
);
    logic taken;
    always_comb begin
        taken  = is_branch && (cond_val == '0);
        pc_nxt = taken ? target : pc + word_t'(1);
    end
endmodule

// File: rtl/sc4_core.sv
module sc4_core
    import sc4_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    output logic [31:0] imem_addr,
    input  logic [31:0] imem_rdata,
    output logic [31:0] dmem_addr,
    input  logic [31:0] dmem_rdata,
    output logic [31:0] dmem_wdata,
    output logic        dmem_we
);
    word_t pc;
    word_t pc_nxt;
    word_t val_x;
    word_t val_y;
    word_t wb_val;
    ctl_t  ctl;

    sc4_decode u_dec (
        .instr (imem_rdata),
        .ctl   (ctl)
    );

    sc4_regfile #(.NREGS(NREGS), .W(XLEN)) u_rf (
        .clk   (clk),
        .rst   (rst),
        .ra_x  (ctl.rx),
        .ra_y  (ctl.ry),
        .rd_x  (val_x),
        .rd_y  (val_y),
        .we    (ctl.rf_we),
        .waddr (ctl.rw),
        .wdata (wb_val)
    );

    sc4_next_pc u_npc (
        .pc        (pc),
        .is_branch (ctl.is_branch),
        .cond_val  (val_x),
        .target    (val_y),
        .pc_nxt    (pc_nxt)
    );

    always_comb begin
        wb_val = ctl.wb_mem ? dmem_rdata : val_x + val_y;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc <= '0;
        end else begin
            pc <= pc_nxt;
        end
    end

    assign imem_addr  = pc;
    assign dmem_addr  = val_y;
    assign dmem_wdata = val_x;
    assign dmem_we    = ctl.mem_we && !rst;

    // R1: reset returns the program counter to zero
    a_r1_pc_zero: assert property (@(posedge clk)
        rst |=> imem_addr == '0);

    // R4: taken branch loads the target register value
    a_r4_bz_target: assert property (@(posedge clk) disable iff (rst)
        (imem_rdata[31:30] == 2'b01 && val_x == '0) |=> imem_addr == $past(val_y));

    // R5: every other case steps by one word
    a_r5_pc_step: assert property (@(posedge clk) disable iff (rst)
        !(imem_rdata[31:30] == 2'b01 && val_x == '0) |=> imem_addr == $past(imem_addr) + 32'd1);

    // R7: a store never writes the register file
    a_r7_store_no_rf: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> !ctl.rf_we);

    // R8: write strobe only for the store opcode
    a_r8_we_store_only: assert property (@(posedge clk) disable iff (rst)
        dmem_we |-> imem_rdata[31:30] == 2'b11);
endmodule

// File: tb/sc4_core_bench.sv
`timescale 1ns/1ps
module sc4_core_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] imem_addr, imem_rdata, dmem_addr, dmem_rdata, dmem_wdata;
    logic        dmem_we;

    logic [31:0] prog  [64];
    logic [31:0] bmem  [64];
    logic [31:0] mmem  [64];
    logic [31:0] mregs [32];
    logic [31:0] mpc;
    string       pc_req;
    int          checks   = 0;
    int          failures = 0;

    always #10 clk = ~clk;

    sc4_core u_sc4_core (
        .clk        (clk),
        .rst        (rst),
        .imem_addr  (imem_addr),
        .imem_rdata (imem_rdata),
        .dmem_addr  (dmem_addr),
        .dmem_rdata (dmem_rdata),
        .dmem_wdata (dmem_wdata),
        .dmem_we    (dmem_we)
    );

    always_comb imem_rdata = prog[imem_addr[5:0]];
    always_comb dmem_rdata = bmem[dmem_addr[5:0]];
    always @(posedge clk) if (dmem_we) bmem[dmem_addr[5:0]] <= dmem_wdata;

    function automatic logic [31:0] enc(int op, int a, int b, int c, int junk);
        logic [31:0] w;
        w = {op[1:0], a[4:0], b[4:0], c[4:0], junk[14:0]};
        return w;
    endfunction

    task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", r, act, exp);
        end
    endtask

    task automatic init_mem();
        for (int i = 0; i < 64; i++) begin
            bmem[i] = 32'h0101_0101 * i + 32'h10;
            prog[i] = enc(1, 0, 0, 0, 0);
        end
        bmem[0] = 32'd1;
        bmem[1] = 32'd2;
        bmem[2] = 32'hFFFF_FFFF;
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        #1;
        chk("R1 pc", imem_addr, 32'd0);
        chk("R1 we", {31'd0, dmem_we}, 32'd0);
        for (int i = 0; i < 32; i++) mregs[i] = 32'd0;
        for (int i = 0; i < 64; i++) mmem[i] = bmem[i];
        mpc    = 32'd0;
        pc_req = "R1";
        rst    = 1'b0;
        #1;
    endtask

    // Compare the current cycle, then advance the reference model.
    task automatic cycle_check();
        logic [31:0] ins;
        int op, a, b, c;
        ins = prog[mpc[5:0]];
        op  = int'(ins[31:30]);
        a   = int'(ins[29:25]);
        b   = int'(ins[24:20]);
        c   = int'(ins[19:15]);
        chk({pc_req, " R9 pc"}, imem_addr, mpc);
        chk("R8 R2 we", {31'd0, dmem_we}, {31'd0, op == 3});
        if (op == 3) begin
            chk("R7 R9 addr", dmem_addr, mregs[b]);
            chk("R7 R9 wdata", dmem_wdata, mregs[a]);
        end
        if (op == 2) chk("R6 R9 addr", dmem_addr, mregs[b]);
        case (op)
            0: begin mregs[a] = mregs[b] + mregs[c]; pc_req = "R3"; end
            1: pc_req = (mregs[a] == 0) ? "R4" : "R5";
            2: begin mregs[a] = mmem[mregs[b][5:0]]; pc_req = "R6"; end
            default: begin mmem[mregs[b][5:0]] = mregs[a]; pc_req = "R7"; end
        endcase
        if (mpc == 32'hFFFF_FFFF && op != 1) pc_req = "R10";
        if (op == 1 && mregs[a] == 0) mpc = mregs[b];
        else mpc = mpc + 32'd1;
        if (mpc == 32'd0 && pc_req == "R5") pc_req = "R10";
    endtask

    task automatic run(int n);
        for (int k = 0; k < n; k++) begin
            if (k > 0) begin
                @(negedge clk);
                #1;
            end
            cycle_check();
        end
    endtask

    initial begin
        // Program A: loads chained through registers, add wrap, store then load, loop
        init_mem();
        prog[0] = enc(2, 1, 0, 9, 16'h5A5A);   // r1 = mem[r0]          R6, R2 junk
        prog[1] = enc(2, 2, 1, 0, 0);          // r2 = mem[r1]          R9 RAW
        prog[2] = enc(2, 3, 2, 31, 16'h7FFF);  // r3 = mem[r2] = all ones
        prog[3] = enc(0, 4, 3, 1, 16'h1234);   // r4 = r3 + r1 wraps    R3
        prog[4] = enc(0, 5, 2, 2, 0);          // r5 = r2 + r2
        prog[5] = enc(3, 5, 1, 7, 16'h0F0F);   // mem[r1] = r5          R7
        prog[6] = enc(2, 6, 1, 0, 0);          // r6 = mem[r1]          store then load
        prog[7] = enc(0, 1, 1, 1, 0);          // r1 = r1 + r1          dest equals source
        prog[8] = enc(1, 5, 2, 3, 16'h3333);   // not taken             R5
        prog[9] = enc(1, 4, 5, 8, 0);          // taken to r5           R4
        do_reset();
        run(40);

        // Program B: zero registers after reset, branch to 0xFFFFFFFF, PC wrap
        init_mem();
        prog[0]  = enc(2, 1, 0, 0, 0);         // r1 = 1
        prog[1]  = enc(0, 2, 1, 1, 0);         // r2 = 2
        prog[2]  = enc(2, 3, 2, 0, 0);         // r3 = all ones
        prog[3]  = enc(1, 0, 3, 21, 16'h4444); // r0 is zero: jump to all ones  R4
        prog[63] = enc(3, 6, 31, 0, 0);        // store r6 (reset zero) at r31  R1, R10
        do_reset();
        run(30);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        failures++;
        $display("FAIL watchdog actual=%h expected=%h", 32'd1, 32'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule